// File: doc/BRIEF.md
# Instruction Fetch Address Unit with Circular Return Stack

This block produces the instruction fetch address for a small accumulator-style processor. A 13-bit program counter register is updated once per clock. The decoder supplies one-cycle strobes that select the next value: the next sequential address, a jump or call target, a return address, the interrupt entry point, or a new low byte written as data. Branch targets carry only the low 11 address bits. The missing upper bits come from a separate 5-bit page register, and a write to the low byte takes all five page bits as the upper PC bits.

Return addresses are held in an eight-level hardware stack that software cannot reach. The stack pointer is a free-running modular counter, so pushes past the eighth overwrite the oldest entries and pops past the bottom wrap around without any error indication. The fetch address is given as the full 13-bit value and also reduced to the implemented memory size, so addresses beyond that size alias onto it.

Top module: `pcu_fetch_addr`

## Requirements
- R1: A synchronous reset that is high at a clock edge sets the PC to 0x0000, the page register to 0 and the stack pointer to 0.
- R2: An increment strobe acting alone sets the PC to PC+1 at the next edge. 0x1FFF advances to 0x0000.
- R3: A jump loads PC[10:0] from the 11-bit target and PC[12:11] from page register bits 4:3.
- R4: A call pushes PC+1 onto the stack and loads the PC in the same way as a jump.
- R5: A return pops the most recent stack entry into all 13 PC bits. The page register plays no part in this.
- R6: An interrupt pushes the current fetch address and loads 0x0004. It overrides every other strobe in the same cycle.
- R7: A low-byte write loads PC[7:0] from the 8-bit data value and PC[12:8] from the five page-register bits.
- R8: A page write does not change the PC. The new page value first affects a branch in the cycle after the write. Pushes and pops leave the page register unchanged.
- R9: The stack holds 8 entries. The ninth push overwrites the first entry. After nine pushes, nine pops return pushes 9, 8, …, 2 and then push 9 again.
- R10: When several strobes are active together, the priority is interrupt, then return, then call, then jump, then low-byte write, then increment.
- R11: mem_addr_o equals the fetch address modulo 2^IMPL_AW (default 11 bits, 2K words).
- R12: With no strobe active, the PC holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Branch to the paged target |
| call_i | input | 1 | Branch to the paged target and save the return address |
| ret_i | input | 1 | Restore the PC from the stack |
| irq_i | input | 1 | Interrupt entry |
| wr_low_i | input | 1 | Write the low PC byte from data_i |
| target_i | input | 11 | Branch target low bits |
| data_i | input | 8 | Low-byte write value |
| page_wr_i | input | 1 | Load the page register |
| page_data_i | input | 5 | Page register write value |
| fetch_addr_o | output | 13 | Registered program counter |
| mem_addr_o | output | 11 | Fetch address reduced to the implemented memory size |

## Verification
The stack wrap is the hardest case to reach from the ports. It only appears once more calls have been made than the stack has levels, followed by enough returns to pass the bottom again. The stimulus makes nine nested calls, each to a different paged target, so every saved address is distinct. It then makes nine returns and checks the LIFO order, the aliased ninth entry and the unchanged page bits on a following jump. Strobe collisions are driven on purpose to check the priority order.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_JUMP = 3'd3,
    SRC_CALL = 3'd4,
    SRC_RET  = 3'd5,
    SRC_IRQ  = 3'd6
  } pc_src_e;

  typedef struct packed {
    logic irq;
    logic ret;
    logic call;
    logic jump;
    logic wr_low;
    logic inc;
  } pc_ctl_t;
endpackage

// File: rtl/pcu_src_arbiter.sv
module pcu_src_arbiter
  import pcu_pkg::*;
(
  input  pc_ctl_t ctl,
  output pc_src_e src,
  output logic    push,
  output logic    pop
);
  always_comb begin
    if (ctl.irq)         src = SRC_IRQ;
    else if (ctl.ret)    src = SRC_RET;
    else if (ctl.call)   src = SRC_CALL;
    else if (ctl.jump)   src = SRC_JUMP;
    else if (ctl.wr_low) src = SRC_LOW;
    else if (ctl.inc)    src = SRC_INC;
    else                 src = SRC_HOLD;
  end

  assign push = (src == SRC_IRQ) || (src == SRC_CALL);
  assign pop  = (src == SRC_RET);
endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] d,
  output logic [PAGE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] pop_data
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_inc;
  logic [SP_W-1:0] sp_dec;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign sp_inc = sp + 1'b1;
      assign sp_dec = sp - 1'b1;
    end else begin : g_mod
      assign sp_inc = (sp == LAST) ? '0 : sp + 1'b1;
      assign sp_dec = (sp == '0) ? LAST : sp - 1'b1;
    end
  endgenerate

  // Storage has no reset so that it maps onto plain RAM.
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp_inc;
    else if (pop)  sp <= sp_dec;
  end

  assign pop_data = mem[sp_dec];
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
  import pcu_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int PAGE_W  = 5,
  parameter int DATA_W  = 8,
  parameter int IRQ_VEC = 4
) (
  input  pc_src_e           src,
  input  logic [PC_W-1:0]   pc,
  input  logic [PAGE_W-1:0] page,
  input  logic [TGT_W-1:0]  target,
  input  logic [DATA_W-1:0] data,
  input  logic [PC_W-1:0]   pop_data,
  output logic [PC_W-1:0]   pc_next,
  output logic [PC_W-1:0]   push_data
);
  localparam int HI_W = PC_W - TGT_W;

  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] branch;
  logic [PC_W-1:0] low_wr;

  assign pc_seq = pc + 1'b1;
  assign branch = {page[PAGE_W-1 -: HI_W], target};
  assign low_wr = {page, data};

  always_comb begin
    case (src)
      SRC_IRQ:  pc_next = PC_W'(IRQ_VEC);
      SRC_RET:  pc_next = pop_data;
      SRC_CALL: pc_next = branch;
      SRC_JUMP: pc_next = branch;
      SRC_LOW:  pc_next = low_wr;
      SRC_INC:  pc_next = pc_seq;
      default:  pc_next = pc;
    endcase
  end

  assign push_data = (src == SRC_IRQ) ? pc : pc_seq;
endmodule

// File: rtl/pcu_fetch_addr.sv
module pcu_fetch_addr
  import pcu_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int PAGE_W  = 5,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int IMPL_AW = 11,
  parameter int IRQ_VEC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_i,
  input  logic               jump_i,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic               irq_i,
  input  logic               wr_low_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               page_wr_i,
  input  logic [PAGE_W-1:0]  page_data_i,
  output logic [PC_W-1:0]    fetch_addr_o,
  output logic [IMPL_AW-1:0] mem_addr_o
);
  pc_ctl_t           ctl;
  pc_src_e           src;
  logic              push;
  logic              pop;
  logic [PAGE_W-1:0] page_q;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_next;
  logic [PC_W-1:0]   push_data;
  logic [PC_W-1:0]   pop_data;

  assign ctl = '{irq: irq_i, ret: ret_i, call: call_i, jump: jump_i,
                 wr_low: wr_low_i, inc: inc_i};

  pcu_src_arbiter u_arb (
    .ctl  (ctl),
    .src  (src),
    .push (push),
    .pop  (pop)
  );

  pcu_page_latch #(.PAGE_W(PAGE_W)) u_page (
    .clk (clk),
    .rst (rst),
    .we  (page_wr_i),
    .d   (page_data_i),
    .q   (page_q)
  );

  pcu_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .pop_data  (pop_data)
  );

  pcu_next_addr #(
    .PC_W(PC_W), .TGT_W(TGT_W), .PAGE_W(PAGE_W),
    .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .src       (src),
    .pc        (pc_q),
    .page      (page_q),
    .target    (target_i),
    .data      (data_i),
    .pop_data  (pop_data),
    .pc_next   (pc_next),
    .push_data (push_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign fetch_addr_o = pc_q;
  assign mem_addr_o   = pc_q[IMPL_AW-1:0];
endmodule

// File: rtl/pcu_fetch_addr_chk.sv
module pcu_fetch_addr_chk #(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int PAGE_W  = 5,
  parameter int DATA_W  = 8,
  parameter int IMPL_AW = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               inc_i,
  input logic               jump_i,
  input logic               call_i,
  input logic               ret_i,
  input logic               irq_i,
  input logic               wr_low_i,
  input logic [TGT_W-1:0]   target_i,
  input logic [DATA_W-1:0]  data_i,
  input logic [PAGE_W-1:0]  page_q,
  input logic [PC_W-1:0]    fetch_addr_o,
  input logic [IMPL_AW-1:0] mem_addr_o
);
  localparam int HI_W = PC_W - TGT_W;

  // R1
  reset_vector_chk: assert property (@(posedge clk)
    $past(rst) |-> fetch_addr_o == '0);

  // R6
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    irq_i |=> fetch_addr_o == PC_W'(4));

  // R3
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (jump_i && !irq_i && !ret_i && !call_i) |=>
      fetch_addr_o == {$past(page_q[PAGE_W-1 -: HI_W]), $past(target_i)});

  // R2
  seq_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !irq_i && !ret_i && !call_i && !jump_i && !wr_low_i) |=>
      fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1));

  // R7
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_low_i && !irq_i && !ret_i && !call_i && !jump_i) |=>
      fetch_addr_o == {$past(page_q), $past(data_i)});

  // R4
  call_return_chk: assert property (@(posedge clk) disable iff (rst)
    (call_i && !irq_i && !ret_i) ##1 (ret_i && !irq_i) |=>
      fetch_addr_o == PC_W'($past(fetch_addr_o, 2) + 1'b1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(inc_i || jump_i || call_i || ret_i || irq_i || wr_low_i) |=>
      $stable(fetch_addr_o));

  // R11
  always_comb begin
    mem_alias_chk: assert (mem_addr_o == fetch_addr_o[IMPL_AW-1:0]);
  end
endmodule

bind pcu_fetch_addr pcu_fetch_addr_chk #(
  .PC_W(PC_W), .TGT_W(TGT_W), .PAGE_W(PAGE_W),
  .DATA_W(DATA_W), .IMPL_AW(IMPL_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .inc_i        (inc_i),
  .jump_i       (jump_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .irq_i        (irq_i),
  .wr_low_i     (wr_low_i),
  .target_i     (target_i),
  .data_i       (data_i),
  .page_q       (page_q),
  .fetch_addr_o (fetch_addr_o),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/test_pcu_fetch_addr.sv
module test_pcu_fetch_addr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc_i = 0, jump_i = 0, call_i = 0, ret_i = 0, irq_i = 0, wr_low_i = 0;
  logic [10:0] target_i = '0;
  logic [7:0]  data_i = '0;
  logic        page_wr_i = 0;
  logic [4:0]  page_data_i = '0;
  logic [12:0] fetch_addr_o;
  logic [10:0] mem_addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcu_fetch_addr i_pcu_fetch_addr (
    .clk(clk), .rst(rst), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
    .ret_i(ret_i), .irq_i(irq_i), .wr_low_i(wr_low_i), .target_i(target_i),
    .data_i(data_i), .page_wr_i(page_wr_i), .page_data_i(page_data_i),
    .fetch_addr_o(fetch_addr_o), .mem_addr_o(mem_addr_o)
  );

  // ctl bits {irq,ret,call,jump,wr_low,inc}, page_wr, page_data, target, data, expected PC
  localparam logic [43:0] VEC [18] = '{
    {6'b000001, 1'b0, 5'h00, 11'h000, 8'h00, 13'h0001}, // R2
    {6'b000001, 1'b0, 5'h00, 11'h000, 8'h00, 13'h0002}, // R2
    {6'b000000, 1'b1, 5'h1A, 11'h000, 8'h00, 13'h0002}, // R8 R12
    {6'b000100, 1'b0, 5'h00, 11'h123, 8'h00, 13'h1923}, // R3
    {6'b000010, 1'b0, 5'h00, 11'h000, 8'h5C, 13'h1A5C}, // R7
    {6'b001000, 1'b0, 5'h00, 11'h7F0, 8'h00, 13'h1FF0}, // R4
    {6'b000001, 1'b0, 5'h00, 11'h000, 8'h00, 13'h1FF1}, // R2
    {6'b100001, 1'b0, 5'h00, 11'h000, 8'h00, 13'h0004}, // R6
    {6'b010000, 1'b0, 5'h00, 11'h000, 8'h00, 13'h1FF1}, // R5 R6
    {6'b010000, 1'b0, 5'h00, 11'h000, 8'h00, 13'h1A5D}, // R4 R5
    {6'b000001, 1'b1, 5'h00, 11'h000, 8'h00, 13'h1A5E}, // R8
    {6'b000100, 1'b0, 5'h00, 11'h7FF, 8'h00, 13'h07FF}, // R3 R8
    {6'b001101, 1'b0, 5'h00, 11'h010, 8'h00, 13'h0010}, // R10
    {6'b011100, 1'b0, 5'h00, 11'h3AA, 8'h00, 13'h0800}, // R10 R5
    {6'b000111, 1'b0, 5'h00, 11'h022, 8'h99, 13'h0022}, // R10
    {6'b000011, 1'b0, 5'h00, 11'h000, 8'h99, 13'h0099}, // R10 R7
    {6'b111000, 1'b0, 5'h00, 11'h155, 8'h00, 13'h0004}, // R10 R6
    {6'b010000, 1'b0, 5'h00, 11'h000, 8'h00, 13'h0099}  // R5
  };

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] ctl, input logic pw, input logic [4:0] pd,
                      input logic [10:0] tgt, input logic [7:0] dat);
    {irq_i, ret_i, call_i, jump_i, wr_low_i, inc_i} = ctl;
    page_wr_i = pw; page_data_i = pd; target_i = tgt; data_i = dat;
    @(posedge clk);
    @(negedge clk);
    {irq_i, ret_i, call_i, jump_i, wr_low_i, inc_i} = '0;
    page_wr_i = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] pushed [9];
    logic [12:0] pc_m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset PC", fetch_addr_o, 13'h0000);
    check("R1 reset mem addr", {2'b00, mem_addr_o}, 13'h0000);

    for (int i = 0; i < 18; i++) begin
      step(VEC[i][43:38], VEC[i][37], VEC[i][36:32], VEC[i][31:21], VEC[i][20:13]);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8/R10/R12 vector %0d", i), fetch_addr_o, VEC[i][12:0]);
      check($sformatf("R11 vector %0d", i), {2'b00, mem_addr_o}, VEC[i][12:0] & 13'h07FF);
    end

    // R2 wrap at top of address space, R11 alias
    step(6'b000000, 1'b1, 5'h1F, 11'h0, 8'h00);
    step(6'b000010, 1'b0, 5'h00, 11'h0, 8'hFF);
    check("R7 top low write", fetch_addr_o, 13'h1FFF);
    check("R11 alias at top", {2'b00, mem_addr_o}, 13'h07FF);
    step(6'b000001, 1'b0, 5'h00, 11'h0, 8'h00);
    check("R2 wrap to zero", fetch_addr_o, 13'h0000);

    // R9 circular stack: nine nested calls then nine returns
    step(6'b000000, 1'b1, 5'h08, 11'h0, 8'h00);
    step(6'b000100, 1'b0, 5'h00, 11'h020, 8'h00);
    check("R3 page bits 01", fetch_addr_o, 13'h0820);
    pc_m = 13'h0820;
    for (int k = 0; k < 9; k++) begin
      pushed[k] = pc_m + 13'd1;
      pc_m = 13'h0800 | 13'(11'h040 * (k + 1));
      step(6'b001000, 1'b0, 5'h00, 11'(11'h040 * (k + 1)), 8'h00);
      check("R4 call target", fetch_addr_o, pc_m);
    end
    for (int k = 8; k >= 1; k--) begin
      step(6'b010000, 1'b0, 5'h00, 11'h0, 8'h00);
      check($sformatf("R9 pop order slot %0d", k), fetch_addr_o, pushed[k]);
    end
    step(6'b010000, 1'b0, 5'h00, 11'h0, 8'h00);
    check("R9 ninth pop wraps to ninth push", fetch_addr_o, pushed[8]);
    step(6'b000100, 1'b0, 5'h00, 11'h000, 8'h00);
    check("R8 page unchanged by push/pop", fetch_addr_o, 13'h0800);

    // R1 mid-run reset clears the page register
    step(6'b000000, 1'b1, 5'h1F, 11'h0, 8'h00);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset PC mid-run", fetch_addr_o, 13'h0000);
    step(6'b000100, 1'b0, 5'h00, 11'h005, 8'h00);
    check("R1 page cleared by reset", fetch_addr_o, 13'h0005);
    step(6'b000000, 1'b0, 5'h00, 11'h3FF, 8'hAA);
    check("R12 idle hold", fetch_addr_o, 13'h0005);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule